// File: doc/BRIEF.md
# Wake-Up Pin Detector with Flags

This block watches a small set of external wake-up pins and one internal wake-up line, and turns qualifying activity on them into sticky flags and a single combined wake request for a power controller. Each pin has its own enable bit and its own polarity bit. The polarity bit chooses the active sense of the pin: either high level and rising edge, or low level and falling edge. An enabled pin whose synchronised level becomes active sets its flag. The flag stays set until software writes a 1 to the matching bit of a clear register.

The internal line is the OR of several on-chip wake sources. When its enable bit is set, a rising edge of that line sets an internal flag. This flag is not cleared by software. It drops by itself once every internal source has gone low. The wake request output combines all set pin flags whose pins are still enabled with the internal flag.

A `standby_exit` pulse marks the return from a deep low-power state. It keeps the configuration and the flags, and re-arms detection, so a pin that is still held at its active level is reported again. A simple register port with a synchronous write and a combinational read gives access to the enable, polarity, status and clear registers.

Top module: `wkup_detect`

## Requirements
- R1: After `rst_n` is released, the enable register (address 0) reads 0x0100, with all pin enables at 0 and the internal-line enable at 1 in bit 8. The polarity register (address 1) reads 0. The status register (address 2) reads 0 and `wake_req` is 0.
- R2: A pin whose enable bit (address 0, bit i) is 0 never sets its flag, whatever its level.
- R3: Polarity bit i (address 1, bit i) set to 0 makes high level and rising edge active on pin i. Set to 1, it makes low level and falling edge active.
- R4: An enabled pin that becomes active shows its flag at status bit i three clock edges after the pin changes: two synchroniser stages, then the flag register. The flag then stays set after the pin returns to its inactive level.
- R5: Writing the clear register (address 3) with bit i set clears flag i at the next edge. Bits written as 0 leave their flags unchanged. Writes to the status address have no effect.
- R6: If a new detection on pin i and a clear of flag i fall in the same cycle, the flag stays set.
- R7: When the internal-line enable is 1, a rising edge of the OR of `int_src` sets the internal flag (status bit 8) one edge later. When that enable is 0, the rising edge does not set the flag.
- R8: The internal flag drops one edge after all `int_src` bits are 0. The clear register does not affect it.
- R9: `wake_req` is high exactly when some flag i is set while enable i is 1, or when the internal flag is set.
- R10: A `standby_exit` pulse leaves enable, polarity and flag contents unchanged. A pin still held at its active level sets its flag again after the pulse.
- R11: Enabling a pin that already sits at its active level sets its flag one edge after the enable write takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Full block reset, active low, asynchronous |
| standby_exit | input | 1 | One-cycle pulse that re-arms detection after a deep low-power exit |
| wk_pin | input | NPIN | External wake-up pins, asynchronous |
| int_src | input | NSRC | Internal wake sources, synchronous levels |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 enable, 1 polarity, 2 status, 3 clear |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for `bus_addr`, combinational |
| wake_req | output | 1 | Combined wake request |

## Verification
The case hardest to reach from the ports is R6: a detection and a software clear of the same flag landing in the same cycle. To hit it, the flag is first set, the pin is dropped, and then the pin is raised again. After exactly two edges of synchroniser delay, the clear write is placed in the one cycle in which the new detection is registered. A randomised run also mixes clear writes with pin toggles on every cycle, so the coincidence recurs many times, and a bench model tracks every flag cycle by cycle.

// File: rtl/wkup_detect.sv
module wkup_detect #(
  parameter int NPIN    = 6,
  parameter int NSRC    = 3,
  parameter int DW      = 16,
  parameter int INT_BIT = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            standby_exit,
  input  logic [NPIN-1:0] wk_pin,
  input  logic [NSRC-1:0] int_src,
  input  logic            bus_we,
  input  logic [1:0]      bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            wake_req
);
  localparam logic [1:0] A_EN  = 2'd0;
  localparam logic [1:0] A_POL = 2'd1;
  localparam logic [1:0] A_STS = 2'd2;
  localparam logic [1:0] A_CLR = 2'd3;

  logic [NPIN-1:0] en_q, pol_q, s1_q, s2_q, hist_q, flag_q;
  logic            int_en_q, int_prev_q, int_flag_q;

  wire             wr_en   = bus_we && (bus_addr == A_EN);
  wire             wr_pol  = bus_we && (bus_addr == A_POL);
  wire             wr_clr  = bus_we && (bus_addr == A_CLR);
  wire [NPIN-1:0]  act     = en_q & (s2_q ^ pol_q);
  wire [NPIN-1:0]  set_vec = act & ~hist_q;
  wire [NPIN-1:0]  clr_vec = wr_clr ? bus_wdata[NPIN-1:0] : '0;
  wire             int_line = |int_src;
  wire             int_rise = int_line & ~int_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= '0;
      pol_q      <= '0;
      int_en_q   <= 1'b1;
      s1_q       <= '0;
      s2_q       <= '0;
      hist_q     <= '0;
      flag_q     <= '0;
      int_prev_q <= 1'b0;
      int_flag_q <= 1'b0;
    end else begin
      s1_q <= wk_pin;
      s2_q <= s1_q;
      hist_q <= standby_exit ? '0 : act;
      flag_q <= (flag_q & ~clr_vec) | set_vec;
      if (wr_en) begin
        en_q     <= bus_wdata[NPIN-1:0];
        int_en_q <= bus_wdata[INT_BIT];
      end
      if (wr_pol) pol_q <= bus_wdata[NPIN-1:0];
      int_prev_q <= int_line;
      if (int_en_q && int_rise) int_flag_q <= 1'b1;
      else if (!int_line)       int_flag_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_EN: begin
        bus_rdata[NPIN-1:0] = en_q;
        bus_rdata[INT_BIT]  = int_en_q;
      end
      A_POL: bus_rdata[NPIN-1:0] = pol_q;
      A_STS: begin
        bus_rdata[NPIN-1:0] = flag_q;
        bus_rdata[INT_BIT]  = int_flag_q;
      end
      default: bus_rdata = '0;
    endcase
  end

  assign wake_req = (|(flag_q & en_q)) | int_flag_q;
endmodule

module wkup_detect_chk #(
  parameter int NPIN = 6,
  parameter int NSRC = 3,
  parameter int DW   = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NPIN-1:0] en_q,
  input logic [NPIN-1:0] flag_q,
  input logic            int_en_q,
  input logic            int_flag_q,
  input logic [NSRC-1:0] int_src,
  input logic            bus_we,
  input logic [1:0]      bus_addr,
  input logic [DW-1:0]   bus_wdata
);
  logic [NPIN-1:0] clr_seen;
  assign clr_seen = (bus_we && bus_addr == 2'd3) ? bus_wdata[NPIN-1:0] : '0;

  assert_no_rise_when_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q & ~$past(flag_q) & ~$past(en_q)) == '0);

  assert_clear_only_by_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flag_q) & ~flag_q & ~$past(clr_seen)) == '0);

  assert_int_set_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_flag_q) |-> ($past(int_en_q) && $past(|int_src)));

  assert_int_drop_needs_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_flag_q) |-> !$past(|int_src));
endmodule

bind wkup_detect wkup_detect_chk #(.NPIN(NPIN), .NSRC(NSRC), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .flag_q(flag_q), .int_en_q(int_en_q),
  .int_flag_q(int_flag_q), .int_src(int_src), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata));

// File: tb/sim_wkup_detect.sv
`timescale 1ns/1ps
module sim_wkup_detect;
  localparam int NPIN = 6;
  localparam int NSRC = 3;
  localparam int DW   = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic standby_exit = 1'b0;
  logic [NPIN-1:0] wk_pin = '0;
  logic [NSRC-1:0] int_src = '0;
  logic bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd2;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic wake_req;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  wkup_detect #(.NPIN(NPIN), .NSRC(NSRC), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .standby_exit(standby_exit), .wk_pin(wk_pin),
    .int_src(int_src), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .wake_req(wake_req));

  // reference model built from the requirements
  logic [NPIN-1:0] m_en, m_pol, m_s1, m_s2, m_hist, m_flag;
  logic m_ien, m_iprev, m_iflag;
  logic [NPIN-1:0] t_act, t_set, t_clr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en <= '0; m_pol <= '0; m_s1 <= '0; m_s2 <= '0; m_hist <= '0; m_flag <= '0;
      m_ien <= 1'b1; m_iprev <= 1'b0; m_iflag <= 1'b0;
    end else begin
      t_act = m_en & (m_s2 ^ m_pol);
      t_set = t_act & ~m_hist;
      t_clr = (bus_we && bus_addr == 2'd3) ? bus_wdata[NPIN-1:0] : '0;
      m_s1 <= wk_pin;
      m_s2 <= m_s1;
      m_hist <= standby_exit ? '0 : t_act;
      m_flag <= (m_flag & ~t_clr) | t_set;
      if (bus_we && bus_addr == 2'd0) begin m_en <= bus_wdata[NPIN-1:0]; m_ien <= bus_wdata[8]; end
      if (bus_we && bus_addr == 2'd1) m_pol <= bus_wdata[NPIN-1:0];
      m_iprev <= |int_src;
      if (m_ien && (|int_src) && !m_iprev) m_iflag <= 1'b1;
      else if (!(|int_src)) m_iflag <= 1'b0;
    end
  end

  function automatic logic [DW-1:0] exp_status(logic [NPIN-1:0] f, logic i);
    return {7'd0, i, 2'd0, f};
  endfunction

  function automatic logic exp_wake(logic [NPIN-1:0] f, logic [NPIN-1:0] e, logic i);
    return (|(f & e)) | i;
  endfunction

  task automatic check(string tag, logic [DW-1:0] got, logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [DW-1:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 2'd2; bus_wdata = '0;
  endtask

  task automatic rd(logic [1:0] a, output logic [DW-1:0] d);
    bus_we = 1'b0; bus_addr = a; #1; d = bus_rdata; bus_addr = 2'd2;
  endtask

  task automatic cmp_model(string tag);
    logic [DW-1:0] s;
    rd(2'd2, s);
    check(tag, s, exp_status(m_flag, m_iflag));
    check({tag, " wake R9"}, {15'd0, wake_req}, {15'd0, exp_wake(m_flag, m_en, m_iflag)});
  endtask

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    int seed;
    seed = 17;
    v = $urandom(seed);
    step(3);
    rst_n = 1'b1;
    step(1);
    rd(2'd0, v); check("R1 enable reset", v, 16'h0100);
    rd(2'd1, v); check("R1 polarity reset", v, 16'h0000);
    rd(2'd2, v); check("R1 status reset", v, 16'h0000);
    check("R1 wake reset", {15'd0, wake_req}, 16'd0);

    // R2: disabled pin 2 toggles
    wk_pin[2] = 1'b1; step(4); wk_pin[2] = 1'b0; step(4);
    rd(2'd2, v); check("R2 disabled pin no flag", v, 16'h0000);

    // R3/R4: pin0 high-active, latency three edges
    wr(2'd0, 16'h0101);
    wk_pin[0] = 1'b1; step(2);
    rd(2'd2, v); check("R4 not before third edge", v, 16'h0000);
    step(1);
    rd(2'd2, v); check("R3 R4 rising sets flag0", v, 16'h0001);
    check("R9 wake with flag0", {15'd0, wake_req}, 16'd1);
    wk_pin[0] = 1'b0; step(4);
    rd(2'd2, v); check("R4 flag sticky", v, 16'h0001);

    // R5
    wr(2'd3, 16'h003E);
    rd(2'd2, v); check("R5 zero bit no effect", v, 16'h0001);
    wr(2'd2, 16'hFFFF);
    rd(2'd2, v); check("R5 status write ignored", v, 16'h0001);
    wr(2'd3, 16'h0001);
    rd(2'd2, v); check("R5 clear flag0", v, 16'h0000);
    check("R9 wake low after clear", {15'd0, wake_req}, 16'd0);

    // R6: set and clear in the same cycle
    wk_pin[0] = 1'b1; step(3); wk_pin[0] = 1'b0; step(4);
    wk_pin[0] = 1'b1; step(2);
    wr(2'd3, 16'h0001);
    rd(2'd2, v); check("R6 set wins over clear", v, 16'h0001);
    wr(2'd3, 16'h0001); wk_pin[0] = 1'b0; step(3);

    // R3: pin4 low-active level, pin5 falling edge
    wk_pin[5] = 1'b1;
    wr(2'd1, 16'h0030);
    step(3);
    wr(2'd0, 16'h0131);
    step(1);
    rd(2'd2, v); check("R3 low level sets flag4", v, 16'h0010);
    wk_pin[5] = 1'b0; step(3);
    rd(2'd2, v); check("R3 falling sets flag5", v, 16'h0030);
    wr(2'd3, 16'h0030);
    wr(2'd1, 16'h0000); wr(2'd0, 16'h0101); step(3);
    wr(2'd3, 16'h003F);

    // R11: pin3 held high, then enabled
    wk_pin[3] = 1'b1; step(4);
    rd(2'd2, v); check("R11 disabled held pin", v, 16'h0000);
    wr(2'd0, 16'h0109);
    step(1);
    rd(2'd2, v); check("R11 enable on active level", v, 16'h0008);
    wr(2'd3, 16'h0008); step(2);
    rd(2'd2, v); check("R4 no retrigger while held", v, 16'h0000);

    // R10
    standby_exit = 1'b1; step(1); standby_exit = 1'b0; step(1);
    rd(2'd2, v); check("R10 held pin reflagged", v, 16'h0008);
    rd(2'd0, v); check("R10 enable kept", v, 16'h0109);
    rd(2'd1, v); check("R10 polarity kept", v, 16'h0000);
    wk_pin[3] = 1'b0; wr(2'd3, 16'h0008); step(3);

    // R7/R8
    int_src[1] = 1'b1; step(1);
    rd(2'd2, v); check("R7 internal flag set", v, 16'h0100);
    check("R9 wake from internal", {15'd0, wake_req}, 16'd1);
    wr(2'd3, 16'h01FF);
    rd(2'd2, v); check("R8 clear write no effect", v, 16'h0100);
    int_src[1] = 1'b0; step(1);
    rd(2'd2, v); check("R8 internal flag self clears", v, 16'h0000);
    wr(2'd0, 16'h0009);
    int_src[0] = 1'b1; step(2);
    rd(2'd2, v); check("R7 disabled line no flag", v, 16'h0000);
    int_src = '0; step(1);

    // random phase against the model
    for (int k = 0; k < 4000; k++) begin
      cmp_model("R4 R5 R6 random");
      wk_pin = ($urandom % 4 == 0) ? NPIN'($urandom) : wk_pin;
      int_src = ($urandom % 6 == 0) ? NSRC'($urandom) : int_src;
      standby_exit = ($urandom % 50 == 0);
      bus_we = ($urandom % 3 == 0);
      bus_addr = 2'($urandom);
      bus_wdata = DW'($urandom);
      @(negedge clk);
      bus_we = 1'b0; standby_exit = 1'b0;
    end
    cmp_model("R9 final");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule